// File: doc/BRIEF.md
# Configuration Request TLP Engine

This block lets software on a register port run one Type 0 configuration read or write at a time. Software first fills three header words and, for a write, a data word already shifted into its byte lanes. It then sets the start bit in the control word. The engine streams the header words onto an outbound TLP port, followed by the data word when the format field calls for one. It inserts a fresh tag into the second header word on the way out.

Once the header is out, the engine waits for a completion with that same tag on an inbound completion port. It records the 3-bit completion status and the returned doubleword. A completion with any other tag is dropped. A programmable cycle limit bounds the wait: when it runs out, the engine gives up with an abort code and all-ones read data. The start bit reads back as 1 for as long as a request is in progress, so software polls it for completion and then reads the status field to learn the outcome.

Top module: `cfg_tlp_engine`

## Requirements
- R1: After reset, the control word (word address 4) reads 0, the read-data word (address 5) reads 0, and tx_valid is low. The word addresses are: 0 header word 0, 1 header word 1, 2 header word 2, 3 write data, 4 control, 5 read data, 6 cycle limit.
- R2: Writing the control word with bit 0 set while the engine is idle starts one request. From the next cycle, bit 0 reads 1 and the status field (bits 7:5) reads 0.
- R3: A request leaves as beats of 32 bits, each held until tx_ready is high, in this order: header word 0, header word 1, header word 2, then the write data word only when bit 30 of header word 0 is set. tx_last marks the final beat.
- R4: Bits 15:8 of the outgoing header word 1 carry the tag. The tag is 1 for the first request after reset and increases by one, modulo 256, for each later request. These bits read as 0 from the register.
- R5: Only a completion whose tag equals the outstanding tag, arriving after the last header beat and while bit 0 is 1, ends the request. Any other completion changes neither the status field nor the read data.
- R6: A matching completion with status 0 for a read clears bit 0, puts status 0 in bits 7:5, and loads the completion data into the read-data word.
- R7: A matching completion with a non-zero status records that status in bits 7:5 and loads 32'hFFFFFFFF into the read-data word.
- R8: A matching completion with status 0 for a write leaves the read-data word unchanged.
- R9: If no matching completion is accepted, bit 0 clears on the (limit+1)th clock edge after the start write, where limit is the value at address 6. The status then reads 3'b111 and the read data reads 32'hFFFFFFFF.
- R10: When a matching completion arrives in the same cycle as the limit expires, the completion wins and its status and data are recorded.
- R11: While bit 0 is 1, writes to any writable word are ignored: the header words, the write data, the limit, and the control word itself. In particular, no second request starts.
- R12: The limit word is writable while idle and resets to the parameter value (5,000,000 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| tx_valid | output | 1 | Outbound beat valid |
| tx_ready | input | 1 | Outbound beat accepted |
| tx_data | output | 32 | Outbound TLP doubleword |
| tx_last | output | 1 | Final beat of the request |
| cpl_valid | input | 1 | Completion present (single cycle) |
| cpl_tag | input | 8 | Completion tag |
| cpl_status | input | 3 | Completion status, 0 means success |
| cpl_data | input | 32 | Completion payload doubleword |

## Verification
Two events can land in the same clock: acceptance of the matching completion, and expiry of the cycle limit. The bench sets a short limit, counts clock edges from the start write, and presents the completion in exactly the cycle in which the limit expires. It expects the completion's status and data to be recorded, not the abort. It then repeats the test one cycle later and expects the abort code and all-ones data, with the late completion dropped.

// File: rtl/cfg_tlp_pkg.sv
package cfg_tlp_pkg;
  localparam int DW = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } eng_state_e;

  localparam logic [2:0] A_HDR0  = 3'd0;
  localparam logic [2:0] A_HDR1  = 3'd1;
  localparam logic [2:0] A_HDR2  = 3'd2;
  localparam logic [2:0] A_WDATA = 3'd3;
  localparam logic [2:0] A_CTRL  = 3'd4;
  localparam logic [2:0] A_RDATA = 3'd5;
  localparam logic [2:0] A_LIMIT = 3'd6;

  localparam logic [2:0] STAT_TMO     = 3'b111;
  localparam int         FMT_DATA_BIT = 30;
endpackage

// File: rtl/cfg_tlp_regs.sv
module cfg_tlp_regs
  import cfg_tlp_pkg::*;
#(
  parameter int          LIM_W   = 32,
  parameter int unsigned LIM_RST = 5000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             busy_i,
  output logic             start_o,
  input  logic             done_i,
  input  logic [2:0]       done_status_i,
  input  logic             done_load_i,
  input  logic [DW-1:0]    done_rdata_i,
  output logic [DW-1:0]    hdr0_o,
  output logic [23:0]      hdr1_o,
  output logic [DW-1:0]    hdr2_o,
  output logic [DW-1:0]    wdat_o,
  output logic [LIM_W-1:0] limit_o
);
  logic [DW-1:0]    hdr0_q, hdr2_q, wdat_q, rdat_q, rdat_d;
  logic [23:0]      hdr1_q;
  logic [LIM_W-1:0] lim_q;
  logic [2:0]       stat_q, stat_d;
  logic             wr_ok;
  logic             hdr0_en, hdr1_en, hdr2_en, wdat_en, lim_en, stat_en, rdat_en;
  logic [DW-1:0]    lim_rd;

  generate
    if (LIM_W < DW) begin : g_lim_pad
      assign lim_rd = {{(DW-LIM_W){1'b0}}, lim_q};
    end else begin : g_lim_full
      assign lim_rd = lim_q[DW-1:0];
    end
  endgenerate

  always_comb begin
    wr_ok   = we_i && !busy_i;
    hdr0_en = wr_ok && (addr_i == A_HDR0);
    hdr1_en = wr_ok && (addr_i == A_HDR1);
    hdr2_en = wr_ok && (addr_i == A_HDR2);
    wdat_en = wr_ok && (addr_i == A_WDATA);
    lim_en  = wr_ok && (addr_i == A_LIMIT);
    start_o = wr_ok && (addr_i == A_CTRL) && wdata_i[0];
    stat_en = start_o || done_i;
    stat_d  = done_i ? done_status_i : 3'd0;
    rdat_en = done_i && done_load_i;
    rdat_d  = done_rdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr0_q <= '0;
      hdr1_q <= '0;
      hdr2_q <= '0;
      wdat_q <= '0;
      lim_q  <= LIM_W'(LIM_RST);
      stat_q <= '0;
      rdat_q <= '0;
    end else begin
      if (hdr0_en) hdr0_q <= wdata_i;
      if (hdr1_en) hdr1_q <= {wdata_i[31:16], wdata_i[7:0]};
      if (hdr2_en) hdr2_q <= wdata_i;
      if (wdat_en) wdat_q <= wdata_i;
      if (lim_en)  lim_q  <= wdata_i[LIM_W-1:0];
      if (stat_en) stat_q <= stat_d;
      if (rdat_en) rdat_q <= rdat_d;
    end
  end

  always_comb begin
    case (addr_i)
      A_HDR0:  rdata_o = hdr0_q;
      A_HDR1:  rdata_o = {hdr1_q[23:8], 8'h00, hdr1_q[7:0]};
      A_HDR2:  rdata_o = hdr2_q;
      A_WDATA: rdata_o = wdat_q;
      A_CTRL:  rdata_o = {24'h0, stat_q, 4'h0, busy_i};
      A_RDATA: rdata_o = rdat_q;
      A_LIMIT: rdata_o = lim_rd;
      default: rdata_o = '0;
    endcase
  end

  assign hdr0_o  = hdr0_q;
  assign hdr1_o  = hdr1_q;
  assign hdr2_o  = hdr2_q;
  assign wdat_o  = wdat_q;
  assign limit_o = lim_q;

  AST_HDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(hdr0_q) && $stable(hdr1_q) && $stable(hdr2_q) && $stable(wdat_q) && $stable(lim_q)); // R11
  AST_ERR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && (done_status_i != 3'd0)) |=> (rdat_q == '1)); // R7
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> (stat_q == 3'd0)); // R2
endmodule

// File: rtl/cfg_tlp_timer.sv
module cfg_tlp_timer #(
  parameter int LIM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             busy_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             expire_o
);
  logic [LIM_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    expire_o = busy_i && (cnt_q >= limit_i);
    cnt_en   = start_i || (busy_i && !expire_o);
    cnt_d    = start_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> (cnt_q <= limit_i)); // R9
endmodule

// File: rtl/cfg_tlp_ctrl.sv
module cfg_tlp_ctrl
  import cfg_tlp_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] hdr0_i,
  input  logic [23:0]   hdr1_i,
  input  logic [DW-1:0] hdr2_i,
  input  logic [DW-1:0] wdat_i,
  input  logic          expire_i,
  output logic          busy_o,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_last_o,
  input  logic          tx_ready_i,
  input  logic          cpl_valid_i,
  input  logic [7:0]    cpl_tag_i,
  input  logic [2:0]    cpl_status_i,
  input  logic [DW-1:0] cpl_data_i,
  output logic          done_o,
  output logic [2:0]    done_status_o,
  output logic          done_load_o,
  output logic [DW-1:0] done_rdata_o
);
  eng_state_e       state_q, state_d;
  logic [1:0]       beat_q, beat_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic [7:0]       tag_field;
  logic             has_data, last_beat, cpl_hit, tag_en, beat_en;

  generate
    if (TAG_W < 8) begin : g_tag_pad
      assign tag_field = {{(8-TAG_W){1'b0}}, tag_q};
    end else begin : g_tag_full
      assign tag_field = tag_q;
    end
  endgenerate

  always_comb begin
    has_data   = hdr0_i[FMT_DATA_BIT];
    last_beat  = (beat_q == (has_data ? 2'd3 : 2'd2));
    cpl_hit    = cpl_valid_i && (cpl_tag_i == tag_field);
    busy_o     = (state_q != ST_IDLE);
    tx_valid_o = (state_q == ST_SEND);
    tx_last_o  = tx_valid_o && last_beat;
    case (beat_q)
      2'd0:    tx_data_o = hdr0_i;
      2'd1:    tx_data_o = {hdr1_i[23:8], tag_field, hdr1_i[7:0]};
      2'd2:    tx_data_o = hdr2_i;
      default: tx_data_o = wdat_i;
    endcase
  end

  always_comb begin
    state_d       = state_q;
    beat_d        = beat_q;
    tag_d         = tag_q + 1'b1;
    tag_en        = 1'b0;
    beat_en       = 1'b0;
    done_o        = 1'b0;
    done_status_o = STAT_TMO;
    done_rdata_o  = '1;
    done_load_o   = 1'b1;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_SEND;
          beat_d  = 2'd0;
          beat_en = 1'b1;
          tag_en  = 1'b1;
        end
      end
      ST_SEND: begin
        if (expire_i) begin
          state_d = ST_IDLE;
          done_o  = 1'b1;
        end else if (tx_ready_i) begin
          beat_en = 1'b1;
          beat_d  = beat_q + 2'd1;
          if (last_beat) state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (cpl_hit) begin
          state_d       = ST_IDLE;
          done_o        = 1'b1;
          done_status_o = cpl_status_i;
          done_rdata_o  = (cpl_status_i != 3'd0) ? '1 : cpl_data_i;
          done_load_o   = (cpl_status_i != 3'd0) || !has_data;
        end else if (expire_i) begin
          state_d = ST_IDLE;
          done_o  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      tag_q   <= '0;
    end else begin
      state_q <= state_d;
      if (beat_en) beat_q <= beat_d;
      if (tag_en)  tag_q  <= tag_d;
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> ((tx_valid_o && $stable(tx_data_o)) || (state_q == ST_IDLE))); // R3
  AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (state_q == ST_IDLE)); // R11
  AST_TAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(tag_q)); // R4
  AST_CPL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WAIT) && cpl_hit && expire_i) |-> (done_o && (done_status_o == cpl_status_i))); // R10
endmodule

// File: rtl/cfg_tlp_engine.sv
module cfg_tlp_engine
  import cfg_tlp_pkg::*;
#(
  parameter int          LIM_W   = 32,
  parameter int unsigned LIM_RST = 5000000,
  parameter int          TAG_W   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [31:0] tx_data,
  output logic        tx_last,
  input  logic        cpl_valid,
  input  logic [7:0]  cpl_tag,
  input  logic [2:0]  cpl_status,
  input  logic [31:0] cpl_data
);
  logic             busy, start, done, done_load, expire;
  logic [2:0]       done_status;
  logic [DW-1:0]    done_rdata, hdr0, hdr2, wdat;
  logic [23:0]      hdr1;
  logic [LIM_W-1:0] limit;

  cfg_tlp_regs #(.LIM_W(LIM_W), .LIM_RST(LIM_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .busy_i(busy), .start_o(start),
    .done_i(done), .done_status_i(done_status), .done_load_i(done_load),
    .done_rdata_i(done_rdata), .hdr0_o(hdr0), .hdr1_o(hdr1), .hdr2_o(hdr2),
    .wdat_o(wdat), .limit_o(limit)
  );

  cfg_tlp_timer #(.LIM_W(LIM_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_i(busy),
    .limit_i(limit), .expire_o(expire)
  );

  cfg_tlp_ctrl #(.TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .hdr0_i(hdr0), .hdr1_i(hdr1),
    .hdr2_i(hdr2), .wdat_i(wdat), .expire_i(expire), .busy_o(busy),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_last_o(tx_last),
    .tx_ready_i(tx_ready), .cpl_valid_i(cpl_valid), .cpl_tag_i(cpl_tag),
    .cpl_status_i(cpl_status), .cpl_data_i(cpl_data), .done_o(done),
    .done_status_o(done_status), .done_load_o(done_load), .done_rdata_o(done_rdata)
  );
endmodule

// File: tb/cfg_tlp_engine_tb_top.sv
module cfg_tlp_engine_tb_top;
  localparam logic [2:0] A_HDR0 = 3'd0, A_HDR1 = 3'd1, A_HDR2 = 3'd2, A_WDATA = 3'd3;
  localparam logic [2:0] A_CTRL = 3'd4, A_RDATA = 3'd5, A_LIMIT = 3'd6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic tx_valid, tx_last;
  logic tx_ready = 1'b1;
  logic [31:0] tx_data;
  logic cpl_valid = 1'b0;
  logic [7:0] cpl_tag = 8'd0;
  logic [2:0] cpl_status = 3'd0;
  logic [31:0] cpl_data = 32'd0;

  int total = 0;
  int bad = 0;
  int cap_n = 0;
  logic [31:0] cap [0:255];
  logic capl [0:255];
  bit rnd_ready = 1'b0;
  logic [7:0] exp_tag = 8'd0;
  logic [31:0] exp_rdat = 32'd0;

  always #10 clk = ~clk;

  cfg_tlp_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_status(cpl_status),
    .cpl_data(cpl_data)
  );

  always @(posedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      cap[cap_n % 256]  <= tx_data;
      capl[cap_n % 256] <= tx_last;
      cap_n <= cap_n + 1;
    end
  end

  always @(negedge clk) tx_ready <= rnd_ready ? 1'($urandom % 2) : 1'b1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic drive_cpl(logic [7:0] t, logic [2:0] s, logic [31:0] d);
    cpl_valid = 1'b1; cpl_tag = t; cpl_status = s; cpl_data = d;
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  function automatic logic [31:0] mk_hdr0(bit is_wr);
    return {(is_wr ? 3'd2 : 3'd0), 5'd4, 14'd0, 10'd1};
  endfunction

  function automatic logic [31:0] mk_be(int size, logic [1:0] off);
    logic [3:0] m;
    m = (size == 1) ? 4'h1 : (size == 2) ? 4'h3 : 4'hF;
    return {28'd0, 4'(m << off)};
  endfunction

  function automatic logic [31:0] mk_hdr2(logic [7:0] bus, logic [4:0] dev, logic [2:0] fn, logic [9:0] regn);
    return {bus, dev, fn, 4'd0, regn, 2'd0};
  endfunction

  task automatic run_req(bit is_wr, logic [31:0] h1, logic [31:0] h2, logic [31:0] wd,
                         int dly, bit bad_tag, logic [2:0] st, logic [31:0] cd);
    logic [31:0] v;
    int base;
    int nb;
    string lbl;
    wr(A_HDR0, mk_hdr0(is_wr));
    wr(A_HDR1, h1);
    wr(A_HDR2, h2);
    wr(A_WDATA, wd);
    base = cap_n;
    nb = is_wr ? 4 : 3;
    wr(A_CTRL, 32'd1);
    exp_tag = exp_tag + 8'd1;
    rd(A_CTRL, v);
    chk("R2 start busy/status", v & 32'hE1, 32'h1);
    for (int i = 0; i < 200; i++) begin
      if (cap_n >= base + nb) break;
      @(negedge clk);
    end
    chk("R3 beat count", 32'(cap_n - base), 32'(nb));
    chk("R3 dw0", cap[base % 256], mk_hdr0(is_wr));
    chk("R4 dw1 with tag", cap[(base + 1) % 256], {h1[31:16], exp_tag, h1[7:0]});
    chk("R3 dw2", cap[(base + 2) % 256], h2);
    if (is_wr) chk("R3 data dw", cap[(base + 3) % 256], wd);
    chk("R3 last flag", {31'd0, capl[(base + nb - 1) % 256]}, 32'd1);
    chk("R3 not last", {31'd0, capl[base % 256]}, 32'd0);
    repeat (dly) @(negedge clk);
    if (bad_tag) begin
      drive_cpl(exp_tag ^ 8'h5A, 3'd0, 32'h1234_5678);
      rd(A_CTRL, v);
      chk("R5 wrong tag dropped", v, 32'h1);
    end
    drive_cpl(exp_tag, st, cd);
    rd(A_CTRL, v);
    chk("R6 done status", v, {24'd0, st, 5'd0});
    if (st != 3'd0) begin exp_rdat = 32'hFFFF_FFFF; lbl = "R7 error data"; end
    else if (!is_wr) begin exp_rdat = cd; lbl = "R6 read data"; end
    else lbl = "R8 write keeps data";
    rd(A_RDATA, v);
    chk(lbl, v, exp_rdat);
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, h1, h2;
    int k, base;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(A_CTRL, v);  chk("R1 ctrl reset", v, 32'd0);
    rd(A_RDATA, v); chk("R1 rdata reset", v, 32'd0);
    chk("R1 tx_valid reset", {31'd0, tx_valid}, 32'd0);
    rd(A_LIMIT, v); chk("R12 limit reset", v, 32'd5000000);
    wr(A_LIMIT, 32'd1000);
    rd(A_LIMIT, v); chk("R12 limit write", v, 32'd1000);

    // directed read, then write keeping read data
    run_req(1'b0, mk_be(2, 2'd2), mk_hdr2(8'h01, 5'd3, 3'd2, 10'h041), 32'd0, 2, 1'b1, 3'd0, 32'hCAFE_0001);
    run_req(1'b1, mk_be(4, 2'd0), mk_hdr2(8'h00, 5'd0, 3'd0, 10'h004), 32'h0BAD_F00D, 0, 1'b0, 3'd0, 32'd0);
    run_req(1'b0, mk_be(1, 2'd3), mk_hdr2(8'hFF, 5'd31, 3'd7, 10'h3FF), 32'd0, 1, 1'b0, 3'd4, 32'h1111_2222);

    // random requests
    rnd_ready = 1'b1;
    for (int n = 0; n < 24; n++) begin
      int sz;
      bit w;
      logic [2:0] st;
      sz = 1 << ($urandom % 3);
      w  = 1'($urandom % 2);
      st = ($urandom % 2) ? 3'd0 : 3'($urandom % 8);
      h1 = mk_be(sz, 2'($urandom % 4)) | ($urandom & 32'hFFFF_0000);
      h2 = mk_hdr2(8'($urandom), 5'($urandom), 3'($urandom), 10'($urandom));
      run_req(w, h1, h2, $urandom, int'($urandom % 6), 1'($urandom % 4 == 0), st, $urandom);
    end
    rnd_ready = 1'b0;
    repeat (2) @(negedge clk);

    // writes while busy are ignored
    wr(A_HDR0, mk_hdr0(1'b0));
    wr(A_HDR1, 32'h0000_000F);
    wr(A_HDR2, 32'h0203_0040);
    wr(A_WDATA, 32'h5555_AAAA);
    base = cap_n;
    wr(A_CTRL, 32'd1);
    exp_tag = exp_tag + 8'd1;
    wr(A_HDR0, 32'hDEAD_BEEF);
    wr(A_WDATA, 32'h0);
    wr(A_LIMIT, 32'd3);
    wr(A_CTRL, 32'd1);
    repeat (10) @(negedge clk);
    chk("R11 no second request", 32'(cap_n - base), 32'd3);
    rd(A_HDR0, v);  chk("R11 hdr0 kept", v, mk_hdr0(1'b0));
    rd(A_WDATA, v); chk("R11 wdata kept", v, 32'h5555_AAAA);
    rd(A_LIMIT, v); chk("R11 limit kept", v, 32'd1000);
    rd(A_HDR1, v);  chk("R4 tag bits read zero", v, 32'h0000_000F);
    drive_cpl(exp_tag, 3'd0, 32'h7777_8888);
    rd(A_CTRL, v);  chk("R11 finished", v, 32'd0);
    exp_rdat = 32'h7777_8888;

    // timeout with exact length
    wr(A_LIMIT, 32'd6);
    wr(A_CTRL, 32'd1);
    exp_tag = exp_tag + 8'd1;
    k = 0;
    for (int i = 0; i < 50; i++) begin
      rd(A_CTRL, v);
      if (!v[0]) break;
      k++;
      @(negedge clk);
    end
    chk("R9 busy cycles", 32'(k), 32'd7);
    rd(A_CTRL, v);  chk("R9 abort status", v, 32'h0000_00E0);
    rd(A_RDATA, v); chk("R9 abort data", v, 32'hFFFF_FFFF);

    // completion in the expiry cycle wins
    wr(A_CTRL, 32'd1);
    exp_tag = exp_tag + 8'd1;
    repeat (6) @(negedge clk);
    drive_cpl(exp_tag, 3'd0, 32'hA5A5_0F0F);
    rd(A_CTRL, v);  chk("R10 completion wins status", v, 32'd0);
    rd(A_RDATA, v); chk("R10 completion wins data", v, 32'hA5A5_0F0F);

    // completion one cycle late is dropped
    wr(A_CTRL, 32'd1);
    exp_tag = exp_tag + 8'd1;
    repeat (7) @(negedge clk);
    drive_cpl(exp_tag, 3'd0, 32'h0101_0101);
    rd(A_CTRL, v);  chk("R10 late completion aborted", v, 32'h0000_00E0);
    rd(A_RDATA, v); chk("R5 late completion dropped", v, 32'hFFFF_FFFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule